// File: doc/BRIEF.md
# Monitor Command Slave with Conversion-Gated Reads

This block is the two-wire serial slave front end of a voltage and current monitor. It answers a bare address probe, and it accepts a single command byte. The bits of that byte start continuous or single conversions of voltage or current, select the voltage range, or turn the next read into a status read. Converter handshakes run on a pulse interface: a start pulse with a quantity select goes out, and a done pulse with a result word comes back. The block keeps the latest result.

A read is gated by the conversion state. While a single conversion is still pending, the address byte of a read gets no acknowledge. In continuous mode, a read that arrives before the first result of the new command is acknowledged and returns zeros. The data always arrives as two bytes, most significant byte first. A first data byte with its top bit set is an extended-register write: it is flagged with a pulse and leaves the command bits untouched.

SCL and SDA pass through a synchronizer of parameter depth. START and STOP are recognised from SDA edges while SCL is high. The open-drain pin is modelled by `sdaOe`, which pulls SDA low when it is 1.

Top module: `mon_cmd_slave`

## Requirements
- R1: An address byte that matches `SLAVE_ADDR` with the write bit (bit 0) low is acknowledged. A STOP right after that acknowledge (a probe with no data byte) leaves the command bits unchanged. The slave only starts pulling SDA while SCL is low.
- R2: An address byte that does not match gets no acknowledge. SDA stays released for every following byte until the next START.
- R3: After a matching write, a data byte with bit 7 = 0 is acknowledged and loaded as the command. Bit 4 of the command drives `rangeSel` (1 = narrow range). Bit 5 is ignored. Only the first data byte of a transfer is taken and acknowledged.
- R4: A first data byte with bit 7 = 1 is acknowledged. It raises `extWrStb` for exactly one cycle, and the command bits, `rangeSel` and the conversion activity do not change.
- R5: With command bit 0 set, voltage conversions (`convIsCurrent` = 0 at `convStart`) are restarted after every `convDone`. A read returns the latest result.
- R6: Command bits 1 (voltage) and 3 (current) each request one conversion. The bit clears itself when that conversion's `convDone` arrives. While a requested single conversion is pending, a read address byte is not acknowledged. A single request issues exactly one `convStart`.
- R7: Writing a command clears the held result. A read in continuous mode before the first `convDone` is acknowledged and returns 0x0000.
- R8: With command bit 6 set, a read is acknowledged even while a single conversion is pending. It returns `statusIn` as the first byte and 0x00 as the second.
- R9: Read data is two bytes, most significant byte first. The result is right-aligned in 16 bits with zeros above it. After the master's NACK the slave releases SDA.
- R10: After reset all command bits are 0, and `sdaOe`, `convStart`, `rangeSel` and `extWrStb` are low.
- R11: Current is converted (`convIsCurrent` = 1) only when neither voltage bit (0 or 1) is set and bit 2 or bit 3 is.
- R12: A START that arrives in the middle of a byte drops the partial byte, and a new address byte is received from that START onwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock pin level |
| sdaIn | input | 1 | Serial data pin level |
| sdaOe | output | 1 | 1 pulls SDA low |
| statusIn | input | 8 | Status byte returned on status reads |
| convDone | input | 1 | One-cycle pulse: conversion finished |
| convResult | input | RES_W | Result word, valid with convDone |
| convStart | output | 1 | One-cycle pulse: start a conversion |
| convIsCurrent | output | 1 | Quantity of the started conversion (1 = current) |
| rangeSel | output | 1 | Voltage range select, command bit 4 |
| extWrStb | output | 1 | One-cycle pulse on an extended-register write |

## Verification
The bound checker watches, on every cycle, that the slave begins pulling SDA only while SCL is low and that start and extended-write strobes last one cycle. It also checks that each converter start picks voltage or current in line with the command bits, and that an extended write never moves the command bits. Read gating cannot be seen from single cycles: NACK while a single conversion is pending, zeros before the first continuous result, and the status substitution. The same holds for byte order, self-clearing one-shots, restart from a repeated START, and silence after a foreign address. The bench scenarios show these with a converter model whose latency can be set longer or shorter than a whole read.

// File: rtl/mon_cmd_pkg.sv
package mon_cmd_pkg;
  localparam int CMD_W  = 7;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_WACK, ST_WBYTE, ST_RACK, ST_RBIT, ST_MACK
  } busState_t;

  // strobes from the bus engine to the datapath
  typedef struct packed {
    logic rxShift;
    logic rxBit;
    logic cmdWr;
    logic txLoad;
    logic txShift;
  } strobes_t;
endpackage

// File: rtl/mon_cmd_ctrl.sv
module mon_cmd_ctrl
  import mon_cmd_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h2A,
  parameter int         SYNC_W     = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              readAck,
  input  logic              txMsb,
  output strobes_t          stb,
  output logic              sdaOe
);
  localparam logic [3:0] LAST_BIT = 4'(BYTE_W - 1);
  localparam logic [3:0] FULL     = 4'(BYTE_W);

  logic [SYNC_W:0] sclPipe, sdaPipe;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
    end else begin
      sclPipe <= {sclPipe[SYNC_W-1:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_W-1:0], sdaIn};
    end
  end

  logic sclS, sclOld, sdaS, sdaOld;
  assign sclS   = sclPipe[SYNC_W-1];
  assign sclOld = sclPipe[SYNC_W];
  assign sdaS   = sdaPipe[SYNC_W-1];
  assign sdaOld = sdaPipe[SYNC_W];

  logic sclRise, sclFall, startDet, stopDet;
  assign sclRise  = sclS & ~sclOld;
  assign sclFall  = ~sclS & sclOld;
  assign startDet = sclS & sclOld & sdaOld & ~sdaS;
  assign stopDet  = sclS & sclOld & ~sdaOld & sdaS;

  busState_t  state;
  logic [3:0] cnt;
  logic       ackOe, cmdPhase, mAck, byteIdx;
  logic       addrHit;
  assign addrHit = (rxByte[BYTE_W-1:1] == SLAVE_ADDR);

  always_comb begin
    stb         = '0;
    stb.rxBit   = sdaS;
    stb.rxShift = sclRise && (state == ST_ADDR || state == ST_WBYTE);
    stb.cmdWr   = sclFall && state == ST_WBYTE && cnt == FULL;
    stb.txLoad  = sclFall && state == ST_ADDR && cnt == FULL && addrHit
                  && rxByte[0] && readAck;
    stb.txShift = sclFall && ((state == ST_RBIT && cnt != LAST_BIT) ||
                              (state == ST_MACK && mAck && !byteIdx));
  end

  assign sdaOe = ackOe | (state == ST_RBIT && !txMsb);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      ackOe    <= 1'b0;
      cmdPhase <= 1'b0;
      mAck     <= 1'b0;
      byteIdx  <= 1'b0;
    end else if (startDet) begin
      state    <= ST_ADDR;
      cnt      <= '0;
      ackOe    <= 1'b0;
      cmdPhase <= 1'b0;
      byteIdx  <= 1'b0;
    end else if (stopDet) begin
      state <= ST_IDLE;
      ackOe <= 1'b0;
    end else begin
      case (state)
        ST_ADDR: begin
          if (sclRise) cnt <= cnt + 4'd1;
          else if (sclFall && cnt == FULL) begin
            if (addrHit && !rxByte[0]) begin
              state <= ST_WACK;
              ackOe <= 1'b1;
            end else if (addrHit && readAck) begin
              state <= ST_RACK;
              ackOe <= 1'b1;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_WACK: if (sclFall) begin
          ackOe <= 1'b0;
          cnt   <= '0;
          state <= cmdPhase ? ST_IDLE : ST_WBYTE;
        end
        ST_WBYTE: begin
          if (sclRise) cnt <= cnt + 4'd1;
          else if (sclFall && cnt == FULL) begin
            ackOe    <= 1'b1;
            cmdPhase <= 1'b1;
            state    <= ST_WACK;
          end
        end
        ST_RACK: if (sclFall) begin
          ackOe <= 1'b0;
          cnt   <= '0;
          state <= ST_RBIT;
        end
        ST_RBIT: if (sclFall) begin
          if (cnt == LAST_BIT) state <= ST_MACK;
          else cnt <= cnt + 4'd1;
        end
        ST_MACK: begin
          if (sclRise) mAck <= ~sdaS;
          else if (sclFall) begin
            if (mAck && !byteIdx) begin
              byteIdx <= 1'b1;
              cnt     <= '0;
              state   <= ST_RBIT;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mon_cmd_dpath.sv
module mon_cmd_dpath
  import mon_cmd_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [BYTE_W-1:0] statusIn,
  input  logic              convDone,
  input  logic [RES_W-1:0]  convResult,
  output logic [BYTE_W-1:0] rxByte,
  output logic              txMsb,
  output logic              readAck,
  output logic [CMD_W-1:0]  cmdQ,
  output logic              convStart,
  output logic              convIsCurrent,
  output logic              extWrStb
);
  localparam logic [CMD_W-1:0] CMD_MASK = 7'h5F;  // bit 5 unused

  logic [RES_W-1:0]  resultQ;
  logic [WORD_W-1:0] txReg, wordOut;
  logic              busy, convOnce, anyConv, pickCur;

  assign rxByte  = rxByteQ;
  logic [BYTE_W-1:0] rxByteQ;
  assign txMsb   = txReg[WORD_W-1];
  assign readAck = cmdQ[6] | ~(cmdQ[1] | cmdQ[3]);
  assign anyConv = |cmdQ[3:0];
  assign pickCur = ~(cmdQ[0] | cmdQ[1]);
  assign wordOut = cmdQ[6] ? {statusIn, {BYTE_W{1'b0}}} : WORD_W'(resultQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByteQ       <= '0;
      txReg         <= '0;
      cmdQ          <= '0;
      resultQ       <= '0;
      busy          <= 1'b0;
      convOnce      <= 1'b0;
      convStart     <= 1'b0;
      convIsCurrent <= 1'b0;
      extWrStb      <= 1'b0;
    end else begin
      if (stb.rxShift) rxByteQ <= {rxByteQ[BYTE_W-2:0], stb.rxBit};
      if (stb.txLoad) txReg <= wordOut;
      else if (stb.txShift) txReg <= {txReg[WORD_W-2:0], 1'b0};

      extWrStb  <= stb.cmdWr & rxByteQ[BYTE_W-1];
      convStart <= 1'b0;
      if (!busy && anyConv) begin
        convStart     <= 1'b1;
        busy          <= 1'b1;
        convIsCurrent <= pickCur;
        convOnce      <= pickCur ? cmdQ[3] : cmdQ[1];
      end
      if (convDone && busy) begin
        busy    <= 1'b0;
        resultQ <= convResult;
      end

      if (stb.cmdWr && !rxByteQ[BYTE_W-1]) begin
        cmdQ    <= rxByteQ[CMD_W-1:0] & CMD_MASK;
        resultQ <= '0;
      end else if (convDone && busy && convOnce) begin
        if (convIsCurrent) cmdQ[3] <= 1'b0;
        else cmdQ[1] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mon_cmd_slave.sv
module mon_cmd_slave
  import mon_cmd_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h2A,
  parameter int         SYNC_W     = 2,
  parameter int         RES_W      = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             sdaOe,
  input  logic [7:0]       statusIn,
  input  logic             convDone,
  input  logic [RES_W-1:0] convResult,
  output logic             convStart,
  output logic             convIsCurrent,
  output logic             rangeSel,
  output logic             extWrStb
);
  strobes_t          stb;
  logic [BYTE_W-1:0] rxByte;
  logic              txMsb, readAck;
  logic [CMD_W-1:0]  cmdQ;

  mon_cmd_ctrl #(.SLAVE_ADDR(SLAVE_ADDR), .SYNC_W(SYNC_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rxByte(rxByte), .readAck(readAck), .txMsb(txMsb),
    .stb(stb), .sdaOe(sdaOe)
  );

  mon_cmd_dpath #(.RES_W(RES_W)) dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .statusIn(statusIn),
    .convDone(convDone), .convResult(convResult),
    .rxByte(rxByte), .txMsb(txMsb), .readAck(readAck), .cmdQ(cmdQ),
    .convStart(convStart), .convIsCurrent(convIsCurrent), .extWrStb(extWrStb)
  );

  assign rangeSel = cmdQ[4];
endmodule

// File: rtl/mon_cmd_chk.sv
module mon_cmd_chk (
  input logic       clk,
  input logic       rstN,
  input logic       sclIn,
  input logic       sdaOe,
  input logic       convStart,
  input logic       convIsCurrent,
  input logic       extWrStb,
  input logic [6:0] cmdQ
);
  // R1
  oe_low_scl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclIn);

  // R5
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);

  // R4
  ext_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    extWrStb |=> !extWrStb);

  // R4
  ext_keeps_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    extWrStb |-> $stable(cmdQ));

  // R6
  volt_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (convStart && !convIsCurrent) |-> $past(cmdQ[0] | cmdQ[1]));

  // R11
  cur_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (convStart && convIsCurrent) |->
      $past(!(cmdQ[0] | cmdQ[1]) && (cmdQ[2] | cmdQ[3])));
endmodule

bind mon_cmd_slave mon_cmd_chk chk_i (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOe(sdaOe),
  .convStart(convStart), .convIsCurrent(convIsCurrent),
  .extWrStb(extWrStb), .cmdQ(cmdQ)
);

// File: tb/mon_cmd_slave_tb.sv
module mon_cmd_slave_tb_top;
  localparam int         CLK_PERIOD = 10;
  localparam int         Q          = 8;
  localparam logic [6:0] ADDR       = 7'h2A;
  localparam int         RES_W      = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1, sdaDrv = 1'b1;
  logic sdaOe, convStart, convIsCurrent, rangeSel, extWrStb;
  logic convDone;
  logic [RES_W-1:0] convResult;
  logic [7:0] statusIn = 8'h5A;
  logic sdaLine;
  assign sdaLine = sdaDrv & ~sdaOe;

  always #(CLK_PERIOD/2) clk = ~clk;

  mon_cmd_slave #(.SLAVE_ADDR(ADDR), .RES_W(RES_W)) dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .statusIn(statusIn), .convDone(convDone), .convResult(convResult),
    .convStart(convStart), .convIsCurrent(convIsCurrent),
    .rangeSel(rangeSel), .extWrStb(extWrStb)
  );

  int checks = 0, failures = 0;

  // converter model
  int convLat = 40;
  int latCnt = 0;
  logic busyM, selM;
  int vStarts = 0, iStarts = 0, doneCnt = 0, extCnt = 0;
  logic [RES_W-1:0] voltVal = 12'hABC, curVal = 12'h3C5;
  always @(posedge clk) begin
    if (!rstN) begin
      busyM <= 1'b0; convDone <= 1'b0; convResult <= '0; selM <= 1'b0;
    end else begin
      convDone <= 1'b0;
      if (extWrStb) extCnt++;
      if (convStart) begin
        busyM <= 1'b1; latCnt <= convLat; selM <= convIsCurrent;
        if (convIsCurrent) iStarts++; else vStarts++;
      end else if (busyM) begin
        if (latCnt <= 1) begin
          busyM <= 1'b0; convDone <= 1'b1;
          convResult <= selM ? curVal : voltVal;
          doneCnt++;
        end else latCnt <= latCnt - 1;
      end
    end
  end

  // scoreboard
  int    expQ[$];
  int    actQ[$];
  string tagQ[$];
  initial forever begin
    @(negedge clk);
    while (actQ.size() != 0 && expQ.size() != 0) begin
      int a, e; string t;
      a = actQ.pop_front(); e = expQ.pop_front(); t = tagQ.pop_front();
      checks++;
      if (a != e) begin
        failures++;
        $display("FAIL %s actual=%0h expected=%0h", t, a, e);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitQ(); repeat (Q) @(negedge clk); endtask

  task automatic i2cStart();
    sdaDrv = 1'b1; waitQ(); sclDrv = 1'b1; waitQ();
    sdaDrv = 1'b0; waitQ(); sclDrv = 1'b0; waitQ();
  endtask

  task automatic i2cStop();
    sdaDrv = 1'b0; waitQ(); sclDrv = 1'b1; waitQ(); sdaDrv = 1'b1; waitQ();
  endtask

  task automatic clockBit(input logic b, output logic s);
    sdaDrv = b; waitQ(); sclDrv = 1'b1; waitQ(); s = sdaLine; waitQ();
    sclDrv = 1'b0; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] v, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clockBit(v[i], s);
    clockBit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recvByte(input logic mAck, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clockBit(1'b1, s); v[i] = s;
    end
    clockBit(~mAck, s);
  endtask

  task automatic writeCmd(input string tag, input logic [7:0] cmd);
    logic a;
    i2cStart();
    sendByte({ADDR, 1'b0}, a); expQ.push_back(1); tagQ.push_back({tag, " addr ack"}); actQ.push_back(int'(a));
    sendByte(cmd, a);          expQ.push_back(1); tagQ.push_back({tag, " data ack"}); actQ.push_back(int'(a));
    i2cStop();
  endtask

  task automatic readWord(input string tag, input bit expAck, input logic [15:0] expW);
    logic a; logic [7:0] b0, b1;
    i2cStart();
    sendByte({ADDR, 1'b1}, a);
    expQ.push_back(int'(expAck)); tagQ.push_back({tag, " read ack"}); actQ.push_back(int'(a));
    if (expAck) begin
      expQ.push_back(int'(expW[15:8])); tagQ.push_back({tag, " byte0"});
      expQ.push_back(int'(expW[7:0]));  tagQ.push_back({tag, " byte1"});
      if (a) begin
        recvByte(1'b1, b0); recvByte(1'b0, b1);
        actQ.push_back(int'(b0)); actQ.push_back(int'(b1));
      end else begin
        actQ.push_back(-1); actQ.push_back(-1);
      end
    end
    i2cStop();
  endtask

  task automatic waitDone(input int target);
    for (int k = 0; k < 20000 && doneCnt < target; k++) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic a;
    int v0, d0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 sdaOe", int'(sdaOe), 0);
    chk("R10 convStart", int'(convStart), 0);
    chk("R10 rangeSel", int'(rangeSel), 0);
    chk("R10 extWrStb", int'(extWrStb), 0);

    // R1 probe: address + W, ack, stop
    i2cStart(); sendByte({ADDR, 1'b0}, a); i2cStop();
    chk("R1 probe ack", int'(a), 1);
    repeat (50) @(negedge clk);
    chk("R1 no conversion", vStarts + iStarts, 0);
    chk("R1 range unchanged", int'(rangeSel), 0);

    // R2 foreign address
    i2cStart(); sendByte({7'h15, 1'b0}, a);
    chk("R2 no ack", int'(a), 0);
    sendByte(8'h01, a);
    chk("R2 silent data", int'(a), 0);
    i2cStop();
    repeat (50) @(negedge clk);
    chk("R2 no conversion", vStarts, 0);

    // R3 range bit
    writeCmd("R3", 8'h10);
    repeat (10) @(negedge clk);
    chk("R3 rangeSel", int'(rangeSel), 1);

    // R4 extended write
    writeCmd("R4", 8'h91);
    repeat (50) @(negedge clk);
    chk("R4 strobe count", extCnt, 1);
    chk("R4 range kept", int'(rangeSel), 1);
    chk("R4 no conversion", vStarts + iStarts, 0);

    // R7 / R11 continuous current, read before first result
    convLat = 5000;
    writeCmd("R11", 8'h04);
    readWord("R7 zero", 1'b1, 16'h0000);
    chk("R11 current started", iStarts, 1);
    chk("R11 no voltage", vStarts, 0);
    convLat = 40;
    waitDone(1);
    repeat (20) @(negedge clk);
    readWord("R9 current", 1'b1, {4'h0, curVal});
    writeCmd("R11 stop", 8'h00);
    repeat (200) @(negedge clk);

    // R6 single voltage conversion
    convLat = 3000;
    v0 = vStarts; d0 = doneCnt;
    writeCmd("R6", 8'h02);
    readWord("R6 pending", 1'b0, 16'h0000);
    // R8 status read is acknowledged while pending
    writeCmd("R8", 8'h42);
    readWord("R8 status", 1'b1, {statusIn, 8'h00});
    waitDone(d0 + 1);
    repeat (20) @(negedge clk);
    writeCmd("R6 clear status", 8'h00);
    repeat (20) @(negedge clk);
    v0 = vStarts;
    d0 = doneCnt;
    writeCmd("R6 again", 8'h02);
    waitDone(d0 + 1);
    repeat (20) @(negedge clk);
    readWord("R6 done", 1'b1, {4'h0, voltVal});
    repeat (500) @(negedge clk);
    chk("R6 one start", vStarts - v0, 1);

    // R5 continuous voltage, repeated restarts
    convLat = 30;
    v0 = vStarts;
    writeCmd("R5", 8'h01);
    repeat (400) @(negedge clk);
    chk("R5 restarts", int'(vStarts - v0 >= 3), 1);
    readWord("R5 latest", 1'b1, {4'h0, voltVal});
    // R9 slave released after master NACK
    chk("R9 released", int'(sdaOe), 0);
    writeCmd("R5 stop", 8'h00);
    repeat (200) @(negedge clk);

    // R12 START in the middle of a byte
    i2cStart();
    clockBit(1'b0, a); clockBit(1'b1, a); clockBit(1'b1, a);
    i2cStart();
    sendByte({ADDR, 1'b0}, a);
    chk("R12 restart ack", int'(a), 1);
    sendByte(8'h00, a);
    chk("R12 cmd ack", int'(a), 1);
    i2cStop();
    repeat (20) @(negedge clk);
    chk("R12 range cleared", int'(rangeSel), 0);

    repeat (50) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule